// File: doc/BRIEF.md
# Cache Line Ownership Tag Checker

This block sits beside the tag array of an on-chip cache in a secure processor and decides whether a cache access may use the line it addresses. Each line is labelled with two tags: the identifier of the secure process that last touched it and the virtual address that process used. Identifier zero stands for non-secure code; secure processes always carry a non-zero identifier.

An access marked as needing integrity protection proceeds at once only when the line is valid and both of its tags equal the accessor's identifier and virtual address. Any other protected access must first pass an off-chip integrity verification. The block asks an external verifier to check the line. While that check is outstanding, the block accepts no new accesses. On success, it rewrites the line's tags to the new owner and reports that the access may proceed. On failure, it reports an integrity fault and leaves the tags untouched. Unprotected accesses skip the check and only relabel the line. The block does not store data and does not contain the verifier.

Top module: `own_tag_checker`

## Requirements
- R1: After reset every line is invalid, `req_ready` is 1, and `vfy_req`, `resp_valid`, `resp_pass` and `resp_fault` are 0.
- R2: A protected access to a valid line whose process and address tags both equal the request gives `resp_valid`=1 with `resp_pass`=1 in the cycle after acceptance, without raising `vfy_req`.
- R3: A protected access that differs in process ID or in address, or that targets an invalid line, raises `vfy_req` in the cycle after acceptance, with `vfy_line` equal to the requested line index and no response yet.
- R4: While `vfy_req` is 1, `req_ready` is 0 and any presented request is ignored: it gets no response and changes no tag.
- R5: A verifier acknowledge (`vfy_ack`=1) with `vfy_ok`=1 gives a pass response in the next cycle and relabels the line with the waiting request's process ID and address. A later protected access by that owner therefore hits.
- R6: A verifier acknowledge with `vfy_ok`=0 gives `resp_valid`=1 with `resp_fault`=1 in the next cycle and leaves the line's tags as they were.
- R7: An unprotected access (`req_prot`=0) never raises `vfy_req`. It returns a pass response in the next cycle and relabels the line with the accessor's tags.
- R8: The first protected access to a line after reset always goes to verification, even with process ID 0 and address 0.
- R9: When `resp_valid` is 1, exactly one of `resp_pass` and `resp_fault` is 1. When `resp_valid` is 0, both are 0.
- R10: `vfy_ack` while no verification is pending has no effect: no response is produced and `req_ready` stays 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Access request present |
| req_ready | output | 1 | Block can accept an access this cycle |
| req_line | input | IDX_W | Cache line index |
| req_pid | input | PID_W | Active process identifier (0 = non-secure) |
| req_va | input | VA_W | Virtual address of the access |
| req_prot | input | 1 | Access needs integrity protection |
| vfy_req | output | 1 | Verification of `vfy_line` requested |
| vfy_line | output | IDX_W | Line to verify |
| vfy_ack | input | 1 | Verifier has finished |
| vfy_ok | input | 1 | Verification result, sampled with `vfy_ack` |
| resp_valid | output | 1 | Decision for an access is available |
| resp_pass | output | 1 | Access may proceed |
| resp_fault | output | 1 | Integrity fault |

## Verification
The assertions check the handshake rules on every cycle. They cover the exclusive pass/fault encoding, the stall while a verification is pending, a tag mismatch leading straight into a verify request, and each response being traced to its cause. Other behaviours show up only across several accesses, so only the bench's scenarios and its cycle-by-cycle tag model can show them. These are: the tags being rewritten after a successful check and kept after a failed one, unprotected accesses relabelling a line, and the first protected access after reset being forced into verification.

// File: rtl/tagchk_pkg.sv
package tagchk_pkg;
  typedef enum logic {
    ST_IDLE   = 1'b0,
    ST_VERIFY = 1'b1
  } chk_state_e;
endpackage

// File: rtl/tag_store.sv
module tag_store #(
  parameter int LINES = 16,
  parameter int PID_W = 8,
  parameter int VA_W  = 32,
  localparam int IDX_W = $clog2(LINES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] rd_idx,
  output logic             rd_vld,
  output logic [PID_W-1:0] rd_pid,
  output logic [VA_W-1:0]  rd_va,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [PID_W-1:0] wr_pid,
  input  logic [VA_W-1:0]  wr_va
);
  logic             vld_a [LINES];
  logic [PID_W-1:0] pid_a [LINES];
  logic [VA_W-1:0]  va_a  [LINES];

  for (genvar g = 0; g < LINES; g++) begin : g_line
    logic             sel;
    logic             vld_q;
    logic [PID_W-1:0] pid_q;
    logic [VA_W-1:0]  va_q;
    assign sel = wr_en && (wr_idx == IDX_W'(g));
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        vld_q <= 1'b0;
        pid_q <= '0;
        va_q  <= '0;
      end else if (sel) begin
        vld_q <= 1'b1;
        pid_q <= wr_pid;
        va_q  <= wr_va;
      end
    end
    assign vld_a[g] = vld_q;
    assign pid_a[g] = pid_q;
    assign va_a[g]  = va_q;
  end

  assign rd_vld = vld_a[rd_idx];
  assign rd_pid = pid_a[rd_idx];
  assign rd_va  = va_a[rd_idx];
endmodule

// File: rtl/check_fsm.sv
module check_fsm
  import tagchk_pkg::*;
#(
  parameter int LINES = 16,
  parameter int PID_W = 8,
  parameter int VA_W  = 32,
  localparam int IDX_W = $clog2(LINES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [IDX_W-1:0] req_line,
  input  logic [PID_W-1:0] req_pid,
  input  logic [VA_W-1:0]  req_va,
  input  logic             req_prot,
  output logic [IDX_W-1:0] rd_idx,
  input  logic             rd_vld,
  input  logic [PID_W-1:0] rd_pid,
  input  logic [VA_W-1:0]  rd_va,
  output logic             wr_en,
  output logic [IDX_W-1:0] wr_idx,
  output logic [PID_W-1:0] wr_pid,
  output logic [VA_W-1:0]  wr_va,
  output logic             vfy_req,
  output logic [IDX_W-1:0] vfy_line,
  input  logic             vfy_ack,
  input  logic             vfy_ok,
  output logic             resp_valid,
  output logic             resp_pass,
  output logic             resp_fault
);
  function automatic logic owner_match(input logic vld,
                                       input logic [PID_W-1:0] tag_pid,
                                       input logic [PID_W-1:0] cur_pid,
                                       input logic [VA_W-1:0]  tag_va,
                                       input logic [VA_W-1:0]  cur_va);
    return vld && (tag_pid == cur_pid) && (tag_va == cur_va);
  endfunction

  chk_state_e       state_q;
  logic [IDX_W-1:0] line_q;
  logic [PID_W-1:0] pid_q;
  logic [VA_W-1:0]  va_q;

  // Named internal events
  logic accept, owner_hit, need_verify, verify_done, bypass_wr, relabel_ok;

  assign req_ready   = (state_q == ST_IDLE);
  assign accept      = req_valid && req_ready;
  assign rd_idx      = req_line;
  assign owner_hit   = owner_match(rd_vld, rd_pid, req_pid, rd_va, req_va);
  assign need_verify = accept && req_prot && !owner_hit;
  assign verify_done = (state_q == ST_VERIFY) && vfy_ack;
  assign bypass_wr   = accept && !req_prot;
  assign relabel_ok  = verify_done && vfy_ok;

  assign wr_en  = bypass_wr || relabel_ok;
  assign wr_idx = relabel_ok ? line_q : req_line;
  assign wr_pid = relabel_ok ? pid_q  : req_pid;
  assign wr_va  = relabel_ok ? va_q   : req_va;

  assign vfy_req  = (state_q == ST_VERIFY);
  assign vfy_line = line_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q    <= ST_IDLE;
      line_q     <= '0;
      pid_q      <= '0;
      va_q       <= '0;
      resp_valid <= 1'b0;
      resp_pass  <= 1'b0;
      resp_fault <= 1'b0;
    end else begin
      resp_valid <= 1'b0;
      resp_pass  <= 1'b0;
      resp_fault <= 1'b0;
      if (need_verify) begin
        state_q <= ST_VERIFY;
        line_q  <= req_line;
        pid_q   <= req_pid;
        va_q    <= req_va;
      end else if (accept) begin
        resp_valid <= 1'b1;
        resp_pass  <= 1'b1;
      end else if (verify_done) begin
        state_q    <= ST_IDLE;
        resp_valid <= 1'b1;
        resp_pass  <= vfy_ok;
        resp_fault <= !vfy_ok;
      end
    end
  end

  // R9
  resp_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid ? $onehot({resp_pass, resp_fault}) : !(resp_pass || resp_fault));

  // R4
  stall_while_verify_chk: assert property (@(posedge clk) disable iff (!rst_n)
    vfy_req |-> !req_ready);

  // R3
  miss_to_verify_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && req_prot && !owner_hit) |=> (vfy_req && !resp_valid && vfy_line == $past(req_line)));

  // R6
  fault_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    resp_fault |-> $past(vfy_req && vfy_ack && !vfy_ok));

  // R2 R5 R7
  pass_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    resp_pass |-> $past((req_valid && req_ready) || (vfy_req && vfy_ack && vfy_ok)));

  // R10
  stray_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!vfy_req && vfy_ack && !req_valid) |=> (!resp_valid && req_ready));
endmodule

// File: rtl/own_tag_checker.sv
module own_tag_checker #(
  parameter int LINES = 16,
  parameter int PID_W = 8,
  parameter int VA_W  = 32,
  localparam int IDX_W = $clog2(LINES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [IDX_W-1:0] req_line,
  input  logic [PID_W-1:0] req_pid,
  input  logic [VA_W-1:0]  req_va,
  input  logic             req_prot,
  output logic             vfy_req,
  output logic [IDX_W-1:0] vfy_line,
  input  logic             vfy_ack,
  input  logic             vfy_ok,
  output logic             resp_valid,
  output logic             resp_pass,
  output logic             resp_fault
);
  logic [IDX_W-1:0] rd_idx, wr_idx;
  logic             rd_vld, wr_en;
  logic [PID_W-1:0] rd_pid, wr_pid;
  logic [VA_W-1:0]  rd_va, wr_va;

  tag_store #(.LINES(LINES), .PID_W(PID_W), .VA_W(VA_W)) u_tags (
    .clk(clk), .rst_n(rst_n),
    .rd_idx(rd_idx), .rd_vld(rd_vld), .rd_pid(rd_pid), .rd_va(rd_va),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_pid(wr_pid), .wr_va(wr_va)
  );

  check_fsm #(.LINES(LINES), .PID_W(PID_W), .VA_W(VA_W)) u_fsm (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_line(req_line),
    .req_pid(req_pid), .req_va(req_va), .req_prot(req_prot),
    .rd_idx(rd_idx), .rd_vld(rd_vld), .rd_pid(rd_pid), .rd_va(rd_va),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_pid(wr_pid), .wr_va(wr_va),
    .vfy_req(vfy_req), .vfy_line(vfy_line), .vfy_ack(vfy_ack), .vfy_ok(vfy_ok),
    .resp_valid(resp_valid), .resp_pass(resp_pass), .resp_fault(resp_fault)
  );
endmodule

// File: tb/tb_own_tag_checker.sv
module tb_own_tag_checker;
  localparam int LINES = 16;
  localparam int PID_W = 8;
  localparam int VA_W  = 32;
  localparam int IDX_W = $clog2(LINES);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_prot = 1'b0, vfy_ack = 1'b0, vfy_ok = 1'b0;
  logic [IDX_W-1:0] req_line = '0;
  logic [PID_W-1:0] req_pid = '0;
  logic [VA_W-1:0]  req_va = '0;
  logic req_ready, vfy_req, resp_valid, resp_pass, resp_fault;
  logic [IDX_W-1:0] vfy_line;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  own_tag_checker #(.LINES(LINES), .PID_W(PID_W), .VA_W(VA_W)) dut (.*);

  // Behavioural reference model
  bit          m_vld [LINES];
  int unsigned m_pid [LINES];
  longint unsigned m_va [LINES];
  bit m_busy, m_rv, m_rp, m_rf;
  int unsigned m_line, m_lpid;
  longint unsigned m_lva;

  always @(posedge clk) begin
    if (!rst_n) begin
      foreach (m_vld[i]) begin m_vld[i] = 0; m_pid[i] = 0; m_va[i] = 0; end
      m_busy = 0; m_rv = 0; m_rp = 0; m_rf = 0; m_line = 0;
    end else begin
      m_rv = 0; m_rp = 0; m_rf = 0;
      if (!m_busy) begin
        if (req_valid) begin
          if (!req_prot) begin
            m_vld[req_line] = 1; m_pid[req_line] = req_pid; m_va[req_line] = req_va;
            m_rv = 1; m_rp = 1;
          end else if (m_vld[req_line] && m_pid[req_line] == req_pid && m_va[req_line] == req_va) begin
            m_rv = 1; m_rp = 1;
          end else begin
            m_busy = 1; m_line = req_line; m_lpid = req_pid; m_lva = req_va;
          end
        end
      end else if (vfy_ack) begin
        if (vfy_ok) begin
          m_vld[m_line] = 1; m_pid[m_line] = m_lpid; m_va[m_line] = m_lva;
        end
        m_rv = 1; m_rp = vfy_ok; m_rf = !vfy_ok; m_busy = 0;
      end
    end
  end

  task automatic chk(string req, longint unsigned act, longint unsigned exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Per-cycle comparison against the model (R3 R4 R9 and response tags)
  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk("R4 req_ready", req_ready, !m_busy);
      chk("R3 vfy_req", vfy_req, m_busy);
      if (m_busy) chk("R3 vfy_line", vfy_line, m_line);
      chk("R9 resp_valid", resp_valid, m_rv);
      chk("R9 resp_pass", resp_pass, m_rp);
      chk("R9 resp_fault", resp_fault, m_rf);
    end
  end

  // Watchdog
  always @(posedge clk) begin
    cycles++;
    if (cycles > 50000 && !done) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected<=%0d", cycles, 50000);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic access(int line, int pid, longint unsigned va, bit prot);
    @(negedge clk);
    req_valid = 1; req_line = IDX_W'(line); req_pid = PID_W'(pid); req_va = VA_W'(va); req_prot = prot;
    @(negedge clk);
    req_valid = 0;
  endtask

  task automatic answer(bit ok);
    @(negedge clk);
    vfy_ack = 1; vfy_ok = ok;
    @(negedge clk);
    vfy_ack = 0; vfy_ok = 0;
  endtask

  initial begin
    logic [15:0] lfsr;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk("R1 ready", req_ready, 1);
    chk("R1 vfy_req", vfy_req, 0);
    chk("R1 resp_valid", resp_valid, 0);
    chk("R1 pass/fault", {resp_pass, resp_fault}, 0);

    // R8 fresh line with pid 0, va 0 still verifies
    access(9, 0, 0, 1);
    chk("R8 vfy_req", vfy_req, 1);
    answer(1);
    chk("R8 pass", resp_pass, 1);

    // R3 / R4 / R5: new owner on line 3
    access(3, 5, 32'h1000, 1);
    chk("R3 vfy_req", vfy_req, 1);
    chk("R3 vfy_line", vfy_line, 3);
    chk("R3 no resp", resp_valid, 0);
    access(3, 9, 32'h7777, 0);  // R4 ignored while verifying
    chk("R4 stalled", req_ready, 0);
    chk("R4 no resp", resp_valid, 0);
    answer(1);
    chk("R5 pass", resp_pass, 1);
    access(3, 5, 32'h1000, 1);  // R2 hit after relabel
    chk("R2 hit pass", resp_pass, 1);
    chk("R2 no verify", vfy_req, 0);

    // R6 failure keeps old tags
    access(3, 6, 32'h1000, 1);
    chk("R3 pid mismatch verify", vfy_req, 1);
    answer(0);
    chk("R6 fault", resp_fault, 1);
    access(3, 5, 32'h1000, 1);
    chk("R6 tags kept", resp_pass, 1);

    // R3 address mismatch, then R5 relabel to new address
    access(3, 5, 32'h2000, 1);
    chk("R3 va mismatch verify", vfy_req, 1);
    answer(1);
    access(3, 5, 32'h2000, 1);
    chk("R5 new va hits", resp_pass, 1);

    // R10 stray acknowledge
    answer(1);
    chk("R10 no resp", resp_valid, 0);
    chk("R10 ready", req_ready, 1);

    // R7 unprotected relabel then protected hit
    access(7, 2, 32'hBEEF, 0);
    chk("R7 pass", resp_pass, 1);
    chk("R7 no verify", vfy_req, 0);
    access(7, 2, 32'hBEEF, 1);
    chk("R7 relabel hit", resp_pass, 1);

    // Mixed traffic, checked against the model every cycle
    lfsr = 16'hACE1;
    for (int n = 0; n < 600; n++) begin
      @(negedge clk);
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      req_valid = lfsr[0];
      req_line  = IDX_W'(lfsr[2:1]);
      req_pid   = PID_W'(lfsr[4:3]);
      req_va    = VA_W'(lfsr[6:5]);
      req_prot  = lfsr[7] | lfsr[8];
      vfy_ack   = lfsr[9];
      vfy_ok    = lfsr[10] | lfsr[11];
    end
    @(negedge clk);
    req_valid = 0; vfy_ack = 0;
    repeat (2) @(negedge clk);
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule